// File: doc/BRIEF.md
# Read-Sequence Unlock Detector

This block sits beside a small byte-wide static memory and watches its access stream for a special request. The request asks for a nonvolatile transfer. Each access arrives as a single-cycle strobe. The strobe stands for the chip-enable assertion that clocks the access in. Alongside the strobe come an 11-bit address and a flag that marks the access as a write. A change of address without a strobe is never an access.

The unlock pattern is five read accesses in a fixed order: 0x000, 0x555, 0x2AA, 0x7FF and 0x0F0. A sixth read then picks the operation. A sixth read at 0x70F asks for a store, and one at 0x70E asks for a recall. On that sixth strobe the block raises a registered one-cycle pulse on the matching output. The pulse feeds the transfer engine, which is not part of this block.

Any write, or any read that falls out of order, abandons the attempt. A repeated strobe at the same address counts as a stray read and also abandons it. The output-enable level is not an input, so it cannot influence recognition. While the transfer engine reports busy, all strobes are ignored.

Top module: `rdseq_unlock`

## Requirements
- R1: A synchronous active-high reset returns the detector to idle and drives both pulse outputs low, including when it arrives in the middle of a sequence.
- R2: Reads at 0x000, 0x555, 0x2AA, 0x7FF, 0x0F0 and then 0x70F, all on consecutive strobes, raise `store_pulse` in the clock cycle right after the sixth strobe.
- R3: The same five reads followed by a read at 0x70E raise `recall_pulse` in the clock cycle right after the sixth strobe.
- R4: A strobe with `acc_wr` = 1 at any point abandons the sequence, and no pulse follows for the rest of that attempt.
- R5: A read at an address that is not the next one expected abandons the sequence, and no pulse follows for the rest of that attempt.
- R6: A read at 0x000 that breaks a sequence is taken as the first step of a new attempt, and that new attempt can complete.
- R7: A repeated strobe at the same address counts as a stray read and abandons the sequence.
- R8: While `xfer_busy` = 1, strobes are ignored and the detector is returned to idle. No pulse is raised in that cycle, and no partial sequence survives it.
- R9: After the five prefix reads, a sixth read at any address other than 0x70F or 0x70E raises no pulse and returns the detector to idle.
- R10: Cycles without a strobe leave the sequence state unchanged, whatever the address inputs carry.
- R11: Each pulse lasts exactly one cycle, and the two pulses are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_stb | input | 1 | One-cycle strobe per access (chip-enable assertion) |
| acc_wr | input | 1 | 1 = the strobed access is a write |
| acc_addr | input | 11 | Address of the strobed access |
| xfer_busy | input | 1 | Transfer engine busy; strobes are ignored while high |
| store_pulse | output | 1 | One-cycle store request |
| recall_pulse | output | 1 | One-cycle recall request |

## Verification
The only visible state is the step count, and it shows at the ports only when the sixth strobe arrives. A wrong count therefore appears up to six strobes later. It shows up either as a pulse that should not come after an abort, restart, busy or reset, or as a missing pulse after a clean sequence. The bench ends every attempt with a deciding sixth strobe and samples the pulses one clock after each strobe. This catches a stuck or miscounted step, a wrong restart target, and a busy or write that fails to clear the state. The internal assertions report such faults in the cycle right after the offending strobe.

// File: rtl/rdseq_pkg.sv
package rdseq_pkg;
  localparam int ADDR_W     = 11;
  localparam int PREFIX_LEN = 5;
  localparam int STEP_W     = $clog2(PREFIX_LEN + 1);

  localparam logic [ADDR_W-1:0] TAIL_STORE  = 11'h70F;
  localparam logic [ADDR_W-1:0] TAIL_RECALL = 11'h70E;

  typedef enum logic [1:0] {
    REQ_NONE   = 2'd0,
    REQ_STORE  = 2'd1,
    REQ_RECALL = 2'd2
  } req_e;

  // address expected at each prefix step; order is behaviour
  function automatic logic [ADDR_W-1:0] prefix_addr(input int idx);
    case (idx)
      0:       return 11'h000;
      1:       return 11'h555;
      2:       return 11'h2AA;
      3:       return 11'h7FF;
      4:       return 11'h0F0;
      default: return 11'h000;
    endcase
  endfunction
endpackage

// File: rtl/rdseq_addr_match.sv
module rdseq_addr_match
  import rdseq_pkg::*;
#(
  parameter int AW  = ADDR_W,
  parameter int NPX = PREFIX_LEN
) (
  input  logic [AW-1:0]  addr,
  output logic [NPX-1:0] hit_prefix,
  output logic           hit_store,
  output logic           hit_recall
);
  for (genvar g = 0; g < NPX; g++) begin : g_cmp
    assign hit_prefix[g] = (addr == AW'(prefix_addr(g)));
  end

  assign hit_store  = (addr == AW'(TAIL_STORE));
  assign hit_recall = (addr == AW'(TAIL_RECALL));
endmodule

// File: rtl/rdseq_step_fsm.sv
module rdseq_step_fsm
  import rdseq_pkg::*;
#(
  parameter int NPX = PREFIX_LEN,
  parameter int SW  = STEP_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           stb,
  input  logic           wr,
  input  logic           busy,
  input  logic [NPX-1:0] hit_prefix,
  input  logic           hit_store,
  input  logic           hit_recall,
  output req_e           req
);
  localparam logic [SW-1:0] TAIL_STEP = SW'(NPX);

  logic [SW-1:0]  step_q, step_d;
  logic [NPX-1:0] step_sel;
  logic           at_tail, cur_hit;

  for (genvar g = 0; g < NPX; g++) begin : g_sel
    assign step_sel[g] = (step_q == SW'(g));
  end

  assign at_tail = (step_q == TAIL_STEP);
  assign cur_hit = |(hit_prefix & step_sel);

  always_comb begin
    step_d = step_q;
    req    = REQ_NONE;
    if (busy) begin
      step_d = '0;
    end else if (stb) begin
      if (wr) begin
        step_d = '0;
      end else if (at_tail && hit_store) begin
        req    = REQ_STORE;
        step_d = '0;
      end else if (at_tail && hit_recall) begin
        req    = REQ_RECALL;
        step_d = '0;
      end else if (!at_tail && cur_hit) begin
        step_d = step_q + SW'(1);
      end else if (hit_prefix[0]) begin
        step_d = SW'(1);
      end else begin
        step_d = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) step_q <= '0;
    else     step_q <= step_d;
  end

  // R8
  busy_idle_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> (step_q == '0));

  // R4
  write_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (stb && wr) |=> (step_q == '0));

  // R10
  step_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!stb && !busy) |=> $stable(step_q));

  // R6
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    (stb && !wr && !busy && hit_prefix[0]) |=> (step_q == SW'(1)));
endmodule

// File: rtl/rdseq_pulse_out.sv
module rdseq_pulse_out
  import rdseq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  req_e req,
  output logic store_pulse,
  output logic recall_pulse
);
  always_ff @(posedge clk) begin
    if (rst) begin
      store_pulse  <= 1'b0;
      recall_pulse <= 1'b0;
    end else begin
      store_pulse  <= (req == REQ_STORE);
      recall_pulse <= (req == REQ_RECALL);
    end
  end

  // R11
  excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(store_pulse && recall_pulse));

  // R11
  store_single_chk: assert property (@(posedge clk) disable iff (rst)
    store_pulse |=> !store_pulse);

  // R11
  recall_single_chk: assert property (@(posedge clk) disable iff (rst)
    recall_pulse |=> !recall_pulse);
endmodule

// File: rtl/rdseq_unlock.sv
module rdseq_unlock
  import rdseq_pkg::*;
#(
  parameter int AW  = ADDR_W,
  parameter int NPX = PREFIX_LEN
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_stb,
  input  logic          acc_wr,
  input  logic [AW-1:0] acc_addr,
  input  logic          xfer_busy,
  output logic          store_pulse,
  output logic          recall_pulse
);
  localparam int SW = $clog2(NPX + 1);

  logic [NPX-1:0] hit_prefix;
  logic           hit_store, hit_recall;
  req_e           req;

  rdseq_addr_match #(.AW(AW), .NPX(NPX)) match_i (
    .addr       (acc_addr),
    .hit_prefix (hit_prefix),
    .hit_store  (hit_store),
    .hit_recall (hit_recall)
  );

  rdseq_step_fsm #(.NPX(NPX), .SW(SW)) fsm_i (
    .clk        (clk),
    .rst        (rst),
    .stb        (acc_stb),
    .wr         (acc_wr),
    .busy       (xfer_busy),
    .hit_prefix (hit_prefix),
    .hit_store  (hit_store),
    .hit_recall (hit_recall),
    .req        (req)
  );

  rdseq_pulse_out pulse_i (
    .clk          (clk),
    .rst          (rst),
    .req          (req),
    .store_pulse  (store_pulse),
    .recall_pulse (recall_pulse)
  );

  // R2
  store_src_chk: assert property (@(posedge clk) disable iff (rst)
    store_pulse |-> ($past(acc_stb) && !$past(acc_wr) && !$past(xfer_busy)
                     && ($past(acc_addr) == AW'(TAIL_STORE))));

  // R3
  recall_src_chk: assert property (@(posedge clk) disable iff (rst)
    recall_pulse |-> ($past(acc_stb) && !$past(acc_wr) && !$past(xfer_busy)
                      && ($past(acc_addr) == AW'(TAIL_RECALL))));
endmodule

// File: tb/rdseq_unlock_tb.sv
module rdseq_unlock_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_stb = 1'b0;
  logic        acc_wr = 1'b0;
  logic [10:0] acc_addr = '0;
  logic        xfer_busy = 1'b0;
  logic        store_pulse, recall_pulse;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  rdseq_unlock dut_i (
    .clk          (clk),
    .rst          (rst),
    .acc_stb      (acc_stb),
    .acc_wr       (acc_wr),
    .acc_addr     (acc_addr),
    .xfer_busy    (xfer_busy),
    .store_pulse  (store_pulse),
    .recall_pulse (recall_pulse)
  );

  // entry: {req[3:0], stb, wr, busy, addr[10:0], exp_store, exp_recall}
  localparam int TBL_N = 47;
  localparam logic [19:0] TBL [TBL_N] = '{
    // R2 clean store
    {4'd2, 3'b100, 11'h000, 2'b00}, {4'd2, 3'b100, 11'h555, 2'b00},
    {4'd2, 3'b100, 11'h2AA, 2'b00}, {4'd2, 3'b100, 11'h7FF, 2'b00},
    {4'd2, 3'b100, 11'h0F0, 2'b00}, {4'd2, 3'b100, 11'h70F, 2'b10},
    // R3 clean recall
    {4'd3, 3'b100, 11'h000, 2'b00}, {4'd3, 3'b100, 11'h555, 2'b00},
    {4'd3, 3'b100, 11'h2AA, 2'b00}, {4'd3, 3'b100, 11'h7FF, 2'b00},
    {4'd3, 3'b100, 11'h0F0, 2'b00}, {4'd3, 3'b100, 11'h70E, 2'b01},
    // R10 address change without strobe is not an access
    {4'd10, 3'b100, 11'h000, 2'b00}, {4'd10, 3'b000, 11'h123, 2'b00},
    {4'd10, 3'b100, 11'h555, 2'b00}, {4'd10, 3'b100, 11'h2AA, 2'b00},
    {4'd10, 3'b100, 11'h7FF, 2'b00}, {4'd10, 3'b100, 11'h0F0, 2'b00},
    {4'd10, 3'b100, 11'h70F, 2'b10},
    // R4 write at an expected address aborts
    {4'd4, 3'b100, 11'h000, 2'b00}, {4'd4, 3'b100, 11'h555, 2'b00},
    {4'd4, 3'b110, 11'h2AA, 2'b00}, {4'd4, 3'b100, 11'h7FF, 2'b00},
    {4'd4, 3'b100, 11'h0F0, 2'b00}, {4'd4, 3'b100, 11'h70F, 2'b00},
    // R5 stray read aborts
    {4'd5, 3'b100, 11'h000, 2'b00}, {4'd5, 3'b100, 11'h555, 2'b00},
    {4'd5, 3'b100, 11'h123, 2'b00}, {4'd5, 3'b100, 11'h2AA, 2'b00},
    {4'd5, 3'b100, 11'h7FF, 2'b00}, {4'd5, 3'b100, 11'h0F0, 2'b00},
    {4'd5, 3'b100, 11'h70F, 2'b00},
    // R7 repeated strobe at same address aborts
    {4'd7, 3'b100, 11'h000, 2'b00}, {4'd7, 3'b100, 11'h555, 2'b00},
    {4'd7, 3'b100, 11'h555, 2'b00}, {4'd7, 3'b100, 11'h2AA, 2'b00},
    {4'd7, 3'b100, 11'h7FF, 2'b00}, {4'd7, 3'b100, 11'h0F0, 2'b00},
    {4'd7, 3'b100, 11'h70E, 2'b00},
    // R6 abort by 0x000 restarts as step one
    {4'd6, 3'b100, 11'h000, 2'b00}, {4'd6, 3'b100, 11'h555, 2'b00},
    {4'd6, 3'b100, 11'h000, 2'b00}, {4'd6, 3'b100, 11'h555, 2'b00},
    {4'd6, 3'b100, 11'h2AA, 2'b00}, {4'd6, 3'b100, 11'h7FF, 2'b00},
    {4'd6, 3'b100, 11'h0F0, 2'b00}, {4'd6, 3'b100, 11'h70E, 2'b01}
  };

  task automatic check(input int rq, input logic es, input logic er);
    total++;
    if (store_pulse !== es || recall_pulse !== er) begin
      bad++;
      $display("FAIL R%0d: store/recall=%b%b expected %b%b at %0t",
               rq, store_pulse, recall_pulse, es, er, $time);
    end
  endtask

  // drive one cycle, sample the registered pulses after the capturing edge
  task automatic apply(input int rq, input logic s, input logic w,
                       input logic b, input logic [10:0] a,
                       input logic es, input logic er);
    @(negedge clk);
    acc_stb = s; acc_wr = w; xfer_busy = b; acc_addr = a;
    @(posedge clk);
    #1;
    check(rq, es, er);
  endtask

  task automatic prefix(input int rq);
    apply(rq, 1'b1, 1'b0, 1'b0, 11'h000, 1'b0, 1'b0);
    apply(rq, 1'b1, 1'b0, 1'b0, 11'h555, 1'b0, 1'b0);
    apply(rq, 1'b1, 1'b0, 1'b0, 11'h2AA, 1'b0, 1'b0);
    apply(rq, 1'b1, 1'b0, 1'b0, 11'h7FF, 1'b0, 1'b0);
    apply(rq, 1'b1, 1'b0, 1'b0, 11'h0F0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(1, 1'b0, 1'b0); // R1 outputs low in reset
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < TBL_N; i++) begin
      apply(int'(TBL[i][19:16]), TBL[i][15], TBL[i][14], TBL[i][13],
            TBL[i][12:2], TBL[i][1], TBL[i][0]);
    end

    // R9 wrong sixth address, then lone tails from idle
    prefix(9);
    apply(9, 1'b1, 1'b0, 1'b0, 11'h70D, 1'b0, 1'b0);
    apply(9, 1'b1, 1'b0, 1'b0, 11'h70F, 1'b0, 1'b0);
    apply(9, 1'b1, 1'b0, 1'b0, 11'h70E, 1'b0, 1'b0);

    // R8 busy cycle between strobes clears progress
    apply(8, 1'b1, 1'b0, 1'b0, 11'h000, 1'b0, 1'b0);
    apply(8, 1'b1, 1'b0, 1'b0, 11'h555, 1'b0, 1'b0);
    apply(8, 1'b0, 1'b0, 1'b1, 11'h555, 1'b0, 1'b0);
    apply(8, 1'b1, 1'b0, 1'b0, 11'h2AA, 1'b0, 1'b0);
    apply(8, 1'b1, 1'b0, 1'b0, 11'h7FF, 1'b0, 1'b0);
    apply(8, 1'b1, 1'b0, 1'b0, 11'h0F0, 1'b0, 1'b0);
    apply(8, 1'b1, 1'b0, 1'b0, 11'h70F, 1'b0, 1'b0);
    // R8 first step strobed while busy is ignored
    apply(8, 1'b1, 1'b0, 1'b1, 11'h000, 1'b0, 1'b0);
    apply(8, 1'b1, 1'b0, 1'b0, 11'h555, 1'b0, 1'b0);
    apply(8, 1'b1, 1'b0, 1'b0, 11'h2AA, 1'b0, 1'b0);
    apply(8, 1'b1, 1'b0, 1'b0, 11'h7FF, 1'b0, 1'b0);
    apply(8, 1'b1, 1'b0, 1'b0, 11'h0F0, 1'b0, 1'b0);
    apply(8, 1'b1, 1'b0, 1'b0, 11'h70F, 1'b0, 1'b0);
    // R8 sixth strobe while busy: no pulse, and no pending step remains
    prefix(8);
    apply(8, 1'b1, 1'b0, 1'b1, 11'h70F, 1'b0, 1'b0);
    apply(8, 1'b1, 1'b0, 1'b0, 11'h70F, 1'b0, 1'b0);

    // R2 clean store after busy, then R11 pulse gone next cycle
    prefix(2);
    apply(2, 1'b1, 1'b0, 1'b0, 11'h70F, 1'b1, 1'b0);
    apply(11, 1'b0, 1'b0, 1'b0, 11'h70F, 1'b0, 1'b0);
    prefix(3);
    apply(3, 1'b1, 1'b0, 1'b0, 11'h70E, 1'b0, 1'b1);
    apply(11, 1'b0, 1'b0, 1'b0, 11'h70E, 1'b0, 1'b0);

    // R1 reset in the middle of a sequence
    prefix(1);
    @(negedge clk);
    acc_stb = 1'b0;
    rst = 1'b1;
    @(posedge clk);
    #1;
    check(1, 1'b0, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    apply(1, 1'b1, 1'b0, 1'b0, 11'h70F, 1'b0, 1'b0);

    @(negedge clk);
    acc_stb = 1'b0;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule